// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit integer datapath and a word-wide data memory. For every request it adds a sign-extended 16-bit displacement to a base register value, which gives a byte address. It sends the word part of that address to memory. The two low bits pick the byte lane. Byte, halfword and word accesses are supported. Lanes are numbered big-endian, so the byte at the lowest address of a word is the most significant byte of that word.

On a store the unit drives a byte-enable mask and places the store data in the lanes that are written. On a load it remembers the lane, size, extension mode and destination register index for one cycle. When the synchronous memory returns the word, the unit extracts the selected bytes, extends them and delivers the result with its register index. A halfword or word access that does not sit on its natural boundary raises a fault. A faulting access reaches memory neither as a read nor as a write.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. `mem_word_addr` carries bits 31:2 of that address in the request cycle.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. `align_fault` rises in the request cycle in these cases: a halfword whose address bit 0 is set, a word whose address bits 1:0 are non-zero, or any access with the reserved code. A byte access never faults.
- R3: During a faulting request `mem_rd_en`, `mem_wr_en` and every bit of `mem_byte_en` are low, memory keeps its contents, and `ld_valid` stays low in the next cycle.
- R4: An aligned store raises `mem_wr_en`. `mem_byte_en` bit 3 enables the lane at address offset 0 and bit 0 the lane at offset 3. A byte store enables exactly the addressed lane, a halfword store at offset 0 drives 1100 and at offset 2 drives 0011, and a word store drives 1111.
- R5: In each enabled lane of `mem_wdata`, a byte store carries data bits 7:0. A halfword store carries bits 15:8 at the even offset and bits 7:0 at the odd offset. A word store carries bits 31:24 at offset 0 down to bits 7:0 at offset 3.
- R6: An aligned load raises `mem_rd_en` in the request cycle. Exactly one cycle later `ld_valid` is high and `ld_dest` equals the `req_dest` of that request.
- R7: A byte load returns the byte at address offset k, which is memory word bits (31-8k) down to (24-8k). It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R8: A halfword load at offset 0 returns word bits 31:16 and at offset 2 returns bits 15:0. It is extended according to `req_unsigned` in the same way as a byte load.
- R9: A word load returns the memory word unchanged.
- R10: While reset is asserted `ld_valid` is low. When `req_valid` is low, no read or write enable is raised whatever the other request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | Load extension: 1 zero, 0 sign |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| req_dest | input | 5 | Destination register index for a load |
| align_fault | output | 1 | Misaligned or reserved-size request |
| mem_word_addr | output | 30 | Word address to memory |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_byte_en | output | 4 | Lane enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word returned one cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| ld_dest | output | 5 | Register index for the load result |

## Verification
The only state in the unit is a one-cycle record of a pending load: its lane, size, extension mode and destination index. A corrupted record shows at the ports in the very next cycle as a wrong byte, a wrong extension or a wrong destination index. The bench catches each of these by comparing every returned result against a queue of expected items. Errors in the address path or in the lane mapping show up in the request cycle as a wrong mask or wrong lane data. Errors that affect memory contents are exposed a few cycles later, when the same words are read back and compared against a shadow image the bench keeps by itself.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 16,
   parameter bit RSVD_FAULTS = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   input  acc_size_e         size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              misalign_o
);
   localparam int EXT_W = ADDR_W - OFF_W;

   if (ADDR_W <= OFF_W) begin : g_bad_width
      $error("lsu_addr_gen: ADDR_W must exceed OFF_W");
   end

   logic half_bad;
   logic word_bad;
   logic rsvd_bad;

   assign ea_o     = base_i + {{EXT_W{off_i[OFF_W-1]}}, off_i};
   assign half_bad = ea_o[0];
   assign word_bad = |ea_o[1:0];

   if (RSVD_FAULTS) begin : g_rsvd_fault
      assign rsvd_bad = 1'b1;
   end else begin : g_rsvd_as_word
      assign rsvd_bad = word_bad;
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: misalign_o = 1'b0;
         SZ_HALF: misalign_o = half_bad;
         SZ_WORD: misalign_o = word_bad;
         default: misalign_o = rsvd_bad;
      endcase
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_align_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int LSB_W  = $clog2(LANES)
) (
   input  logic              en_i,
   input  acc_size_e         size_i,
   input  logic [LSB_W-1:0]  lane_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [LANES-1:0]  be_o,
   output logic [DATA_W-1:0] data_o
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LSB_W-1:0] OFS = LSB_W'(LANES - 1 - i);
      logic       sel;
      logic [7:0] d;

      always_comb begin
         case (size_i)
            SZ_BYTE: begin
               sel = (lane_i == OFS);
               d   = wdata_i[7:0];
            end
            SZ_HALF: begin
               sel = (lane_i[LSB_W-1:1] == OFS[LSB_W-1:1]);
               d   = wdata_i[8*(i%2) +: 8];
            end
            default: begin
               sel = 1'b1;
               d   = wdata_i[8*i +: 8];
            end
         endcase
      end

      assign be_o[i]          = en_i & sel;
      assign data_o[8*i +: 8] = d;
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int LSB_W  = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [LSB_W-1:0]  lane_i,
   input  acc_size_e         size_i,
   input  logic              zext_i,
   output logic [DATA_W-1:0] data_o
);
   logic [7:0]  b_sel;
   logic [15:0] h_sel;

   always_comb begin
      b_sel = rdata_i[(LANES - 1 - int'(lane_i)) * 8 +: 8];
      h_sel = rdata_i[(LANES / 2 - 1 - int'(lane_i[LSB_W-1:1])) * 16 +: 16];
      case (size_i)
         SZ_BYTE: data_o = {{(DATA_W-8){~zext_i & b_sel[7]}}, b_sel};
         SZ_HALF: data_o = {{(DATA_W-16){~zext_i & h_sel[15]}}, h_sel};
         default: data_o = rdata_i;
      endcase
   end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
   import lsu_align_pkg::*;
#(
   parameter  int ADDR_W      = 32,
   parameter  int DATA_W      = 32,
   parameter  int OFF_W       = 16,
   parameter  int REG_W       = 5,
   parameter  bit RSVD_FAULTS = 1'b1,
   localparam int LANES       = DATA_W / 8,
   localparam int LSB_W       = $clog2(LANES),
   localparam int WADDR_W     = ADDR_W - LSB_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_store,
   input  logic [1:0]         req_size,
   input  logic               req_unsigned,
   input  logic [ADDR_W-1:0]  req_base,
   input  logic [OFF_W-1:0]   req_offset,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [REG_W-1:0]   req_dest,
   output logic               align_fault,
   output logic [WADDR_W-1:0] mem_word_addr,
   output logic               mem_rd_en,
   output logic               mem_wr_en,
   output logic [LANES-1:0]   mem_byte_en,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               ld_valid,
   output logic [DATA_W-1:0]  ld_data,
   output logic [REG_W-1:0]   ld_dest
);

   if (DATA_W != 32) begin : g_bad_data
      $error("lsu_align: halfword and word sizes assume a 32-bit word");
   end

   acc_size_e         size;
   logic [ADDR_W-1:0] ea;
   logic              misalign;
   logic              ld_take;

   logic              pend_q;
   logic [LSB_W-1:0]  lane_q;
   acc_size_e         size_q;
   logic              zext_q;
   logic [REG_W-1:0]  dest_q;
   logic [DATA_W-1:0] ext_data;

   assign size = acc_size_e'(req_size);

   lsu_addr_gen #(
      .ADDR_W      (ADDR_W),
      .OFF_W       (OFF_W),
      .RSVD_FAULTS (RSVD_FAULTS)
   ) u_addr (
      .base_i     (req_base),
      .off_i      (req_offset),
      .size_i     (size),
      .ea_o       (ea),
      .misalign_o (misalign)
   );

   assign align_fault   = req_valid & misalign;
   assign mem_word_addr = ea[ADDR_W-1:LSB_W];
   assign mem_wr_en     = req_valid & req_store & ~misalign;
   assign mem_rd_en     = req_valid & ~req_store & ~misalign;
   assign ld_take       = mem_rd_en;

   lsu_store_lanes #(
      .DATA_W (DATA_W)
   ) u_store (
      .en_i    (mem_wr_en),
      .size_i  (size),
      .lane_i  (ea[LSB_W-1:0]),
      .wdata_i (req_wdata),
      .be_o    (mem_byte_en),
      .data_o  (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         lane_q <= '0;
         size_q <= SZ_WORD;
         zext_q <= 1'b0;
         dest_q <= '0;
      end else begin
         pend_q <= ld_take;
         if (ld_take) begin
            lane_q <= ea[LSB_W-1:0];
            size_q <= size;
            zext_q <= req_unsigned;
            dest_q <= req_dest;
         end
      end
   end

   lsu_load_extract #(
      .DATA_W (DATA_W)
   ) u_load (
      .rdata_i (mem_rdata),
      .lane_i  (lane_q),
      .size_i  (size_q),
      .zext_i  (zext_q),
      .data_o  (ext_data)
   );

   assign ld_valid = pend_q;
   assign ld_data  = pend_q ? ext_data : '0;
   assign ld_dest  = dest_q;

   a_r2_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0) |-> !align_fault);

   a_r3_fault_blocks_memory: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (!mem_wr_en && !mem_rd_en && mem_byte_en == '0));

   a_r3_no_result_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |=> !ld_valid);

   a_r4_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_byte_en) ==
                     ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)));

   a_r6_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !align_fault) |=> ld_valid);

   a_r6_dest_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> ld_dest == $past(req_dest));

   a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(req_size == 2'd0 && req_unsigned)) |-> ld_data[DATA_W-1:8] == '0);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_wr_en && !mem_rd_en && !align_fault));

endmodule

// File: tb/lsu_align_test.sv
module lsu_align_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic        req_unsigned = 1'b0;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic [4:0]  req_dest = '0;
   logic        align_fault;
   logic [29:0] mem_word_addr;
   logic        mem_rd_en;
   logic        mem_wr_en;
   logic [3:0]  mem_byte_en;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        ld_valid;
   logic [31:0] ld_data;
   logic [4:0]  ld_dest;

   always #5 clk = ~clk;

   lsu_align uut (
      .clk, .rst_n, .req_valid, .req_store, .req_size, .req_unsigned,
      .req_base, .req_offset, .req_wdata, .req_dest, .align_fault,
      .mem_word_addr, .mem_rd_en, .mem_wr_en, .mem_byte_en, .mem_wdata,
      .mem_rdata, .ld_valid, .ld_data, .ld_dest
   );

   logic [31:0] mem    [0:255];
   logic [31:0] shadow [0:255];

   always @(posedge clk) begin
      if (mem_wr_en)
         for (int b = 0; b < 4; b++)
            if (mem_byte_en[b]) mem[mem_word_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_rd_en) mem_rdata <= mem[mem_word_addr[7:0]];
   end

   typedef struct {
      logic [31:0] data;
      logic [4:0]  dest;
      string       tag;
   } exp_t;
   exp_t q[$];

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                         input logic [31:0] base, input logic [15:0] off,
                         input logic [31:0] wd, input logic [4:0] dest, input bit exp_fault);
      logic [31:0] ea, w, exp_v, exp_wd;
      logic [7:0]  idx;
      logic [1:0]  ln;
      logic [3:0]  exp_be;
      @(negedge clk);
      #2;
      req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
      req_base = base; req_offset = off; req_wdata = wd; req_dest = dest;
      #1;
      ea  = base + {{16{off[15]}}, off};
      idx = ea[9:2];
      ln  = ea[1:0];
      chk(mem_word_addr == ea[31:2], "R1 word address", {2'b0, mem_word_addr}, {2'b0, ea[31:2]});
      chk(align_fault == exp_fault, "R2 alignment fault", {31'b0, align_fault}, {31'b0, exp_fault});
      if (exp_fault) begin
         chk(!mem_wr_en && !mem_rd_en && mem_byte_en == 4'b0, "R3 fault suppresses memory",
             {mem_wr_en, mem_rd_en, mem_byte_en}, 32'h0);
      end else if (st) begin
         case (sz)
            2'd0: exp_be = 4'b1000 >> ln;
            2'd1: exp_be = ln[1] ? 4'b0011 : 4'b1100;
            default: exp_be = 4'b1111;
         endcase
         chk(mem_wr_en && mem_byte_en == exp_be, "R4 byte enables",
             {mem_wr_en, mem_byte_en}, {1'b1, exp_be});
         exp_wd = '0;
         for (int o = 0; o < 4; o++) begin
            logic [7:0] v;
            case (sz)
               2'd0: v = wd[7:0];
               2'd1: v = (o % 2 == 0) ? wd[15:8] : wd[7:0];
               default: v = wd[31 - 8*o -: 8];
            endcase
            if (exp_be[3-o]) begin
               exp_wd[31 - 8*o -: 8] = v;
               shadow[idx][31 - 8*o -: 8] = v;
            end
         end
         chk((mem_wdata & {{8{exp_be[3]}}, {8{exp_be[2]}}, {8{exp_be[1]}}, {8{exp_be[0]}}}) == exp_wd,
             "R5 lane data", mem_wdata, exp_wd);
      end else begin
         chk(mem_rd_en && !mem_wr_en, "R6 read strobe", {mem_rd_en, mem_wr_en}, 32'h2);
         w = shadow[idx];
         case (sz)
            2'd0: begin
               exp_v = {24'b0, w[31 - 8*ln -: 8]};
               if (!uns && exp_v[7]) exp_v[31:8] = '1;
               q.push_back('{exp_v, dest, "R7 byte load"});
            end
            2'd1: begin
               exp_v = {16'b0, ln[1] ? w[15:0] : w[31:16]};
               if (!uns && exp_v[15]) exp_v[31:16] = '1;
               q.push_back('{exp_v, dest, "R8 halfword load"});
            end
            default: q.push_back('{w, dest, "R9 word load"});
         endcase
      end
   endtask

   task automatic idle;
      @(negedge clk);
      #2;
      req_valid = 1'b0;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (ld_valid) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R3/R6 unexpected load result", {31'b0, ld_valid}, 32'h0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk(ld_data == e.data, e.tag, ld_data, e.data);
                  chk(ld_dest == e.dest, "R6 destination index", {27'b0, ld_dest}, {27'b0, e.dest});
               end
            end else if (q.size() > 0) begin
               exp_t e;
               e = q.pop_front();
               chk(1'b0, "R6 missing load result", {31'b0, ld_valid}, 32'h1);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]    = {8'(i), 8'(i*3 + 8'h91), 8'(8'hF0 ^ i), 8'(i + 8'h7F)};
         shadow[i] = mem[i];
      end
      // R10: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(!ld_valid, "R10 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
      @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!ld_valid && !mem_wr_en && !mem_rd_en, "R10 idle after reset",
          {ld_valid, mem_wr_en, mem_rd_en}, 32'h0);

      // R9, R1: word loads, positive, negative and wrapping offsets
      access(0, 2'd2, 0, 32'h0000_0040, 16'h0000, '0, 5'd3, 0);
      access(0, 2'd2, 0, 32'h0000_0104, 16'hFFF8, '0, 5'd4, 0);
      access(0, 2'd2, 0, 32'hFFFF_FFF8, 16'h0010, '0, 5'd5, 0);

      // R7: bytes at every offset, signed and unsigned, back to back
      for (int k = 0; k < 4; k++) begin
         access(0, 2'd0, 0, 32'h0000_0010, 16'(4 + k), '0, 5'(8 + k), 0);
         access(0, 2'd0, 1, 32'h0000_0010, 16'(4 + k), '0, 5'(16 + k), 0);
      end
      access(0, 2'd0, 0, 32'h0000_0200, 16'h0001, '0, 5'd1, 0);

      // R8: halfwords at both offsets, both extensions
      access(0, 2'd1, 0, 32'h0000_0060, 16'h0000, '0, 5'd20, 0);
      access(0, 2'd1, 1, 32'h0000_0060, 16'h0000, '0, 5'd21, 0);
      access(0, 2'd1, 0, 32'h0000_0060, 16'h0002, '0, 5'd22, 0);
      access(0, 2'd1, 1, 32'h0000_0060, 16'h0002, '0, 5'd23, 0);
      access(0, 2'd1, 0, 32'h0000_0170, 16'h0002, '0, 5'd24, 0);

      // R4, R5: stores of every size, then read back
      access(1, 2'd0, 0, 32'h0000_0030, 16'h0001, 32'hDEAD_BEEF, 5'd0, 0);
      access(1, 2'd0, 0, 32'h0000_0030, 16'h0003, 32'h0000_0011, 5'd0, 0);
      access(1, 2'd1, 0, 32'h0000_0034, 16'h0002, 32'h1234_CAFE, 5'd0, 0);
      access(1, 2'd1, 0, 32'h0000_0034, 16'h0004, 32'hFFFF_8001, 5'd0, 0);
      access(1, 2'd2, 0, 32'h0000_003C, 16'h0000, 32'h89AB_CDEF, 5'd0, 0);
      access(0, 2'd2, 0, 32'h0000_0030, 16'h0000, '0, 5'd6, 0);
      access(0, 2'd2, 0, 32'h0000_0034, 16'h0000, '0, 5'd7, 0);
      access(0, 2'd2, 0, 32'h0000_0038, 16'h0000, '0, 5'd8, 0);
      access(0, 2'd2, 0, 32'h0000_003C, 16'h0000, '0, 5'd9, 0);

      // R2, R3: misaligned and reserved-size requests
      access(0, 2'd1, 0, 32'h0000_0040, 16'h0003, '0, 5'd10, 1);
      access(1, 2'd1, 0, 32'h0000_0040, 16'h0001, 32'hAAAA_AAAA, 5'd0, 1);
      access(1, 2'd2, 0, 32'h0000_0040, 16'h0002, 32'h5555_5555, 5'd0, 1);
      access(0, 2'd2, 0, 32'h0000_0040, 16'h0001, '0, 5'd11, 1);
      access(1, 2'd2, 0, 32'h0000_0040, 16'h0003, 32'h7777_7777, 5'd0, 1);
      access(1, 2'd3, 0, 32'h0000_0040, 16'h0000, 32'h3333_3333, 5'd0, 1);
      access(0, 2'd3, 0, 32'h0000_0044, 16'h0000, '0, 5'd12, 1);
      access(0, 2'd2, 0, 32'h0000_0040, 16'h0000, '0, 5'd13, 0);

      // R10: store inputs with req_valid low are ignored
      @(negedge clk);
      #2;
      req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2;
      req_base = 32'h0000_0050; req_offset = '0; req_wdata = 32'h0BAD_F00D;
      #1;
      chk(!mem_wr_en && !mem_rd_en && mem_byte_en == 4'b0 && !align_fault,
          "R10 no enables without req_valid", {mem_wr_en, mem_rd_en, mem_byte_en, align_fault}, 32'h0);
      access(0, 2'd2, 0, 32'h0000_0050, 16'h0000, '0, 5'd14, 0);

      idle();
      repeat (3) @(negedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule